// File: doc/BRIEF.md
# Three-Wire Audio Setting Command Receiver

This block takes control words from a host over a three-wire serial bus made of a data line, a bit clock and an active-low enable. It keeps eight setting registers: source select, bass, treble, volume, and four fader levels (left/right, front/rear). Downstream logic uses the register outputs as digital setting codes. The block does no gain arithmetic and no signal processing.

All three bus pins are asynchronous to the system clock. Each pin passes through a multi-stage synchroniser, and edges are detected in the system clock domain. A frame starts when enable falls and is carried out when enable rises. The first two bits of the frame are a device address. Any number of filler bits may follow the address. The nine bits clocked last hold a three-bit function field and a six-bit value. A write can clamp an illegal value to a legal code, and each write raises a one-cycle strobe that carries the index of the register it wrote.

Top module: `tone_cmd_rx`

## Requirements
- R1: A bit is captured on each rising edge of the bus clock, but only while enable is low. Clock edges that arrive while enable is high have no effect on any register.
- R2: A frame is carried out only if its first two bits are 1 and then 0. If the address differs, the frame leaves every register unchanged.
- R3: A frame may be any length of 11 bits or more. The last nine bits before enable rises are the command, sent function MSB first and then value MSB first. A frame shorter than 11 bits is ignored.
- R4: Registers change only after enable rises. Each write raises `upd_o` for exactly one clock, with `upd_idx_o` set to the function code. The function codes are: 0 source, 1 bass, 2 treble, 3 volume, 4 right front fader, 5 left front fader, 6 right rear fader, 7 left rear fader.
- R5: If enable falls while the bus clock is high, that frame is discarded.
- R6: After reset, volume and all four faders are 0, bass and treble are 6 (flat), and source is 0.
- R7: Volume stores all six value bits. The legal range is 0 to 40 in 2 dB steps, and values above 40 are stored as 40.
- R8: A fader stores the low five value bits, and the top value bit is ignored. The legal range is 0 to 20, and values above 20 are stored as 20.
- R9: Bass and treble store the low four value bits. The legal range is 0 to 12, with 6 as flat, and values above 12 are stored as 12.
- R10: Source stores the low three value bits. 0 means open and 1 to 4 pick inputs 1 to 4. The values 5 to 7 are stored as 0.
- R11: A write changes only the register named by its function field. The other seven registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_data_i | input | 1 | Serial data line |
| ser_clk_i | input | 1 | Serial bit clock |
| ser_en_ni | input | 1 | Frame enable, active low |
| src_sel_o | output | 3 | Source select code |
| bass_o | output | 4 | Bass code |
| treble_o | output | 4 | Treble code |
| volume_o | output | 6 | Volume code |
| fade_rf_o | output | 5 | Right front fader code |
| fade_lf_o | output | 5 | Left front fader code |
| fade_rr_o | output | 5 | Right rear fader code |
| fade_lr_o | output | 5 | Left rear fader code |
| upd_o | output | 1 | One-cycle write strobe |
| upd_idx_o | output | 3 | Function code of the write |

## Verification
The bench sends minimum-length frames to every function, which shows that the function decode reaches the right register. Padded frames show that only the last nine bits are used. Frames with a wrong address, frames that are too short, and frames that start with the clock high must produce no strobe and leave every register unchanged. Clock pulses sent while enable is high show that idle bus traffic is ignored. Values above each range, and fader values with the top bit set, separate the clamp from plain truncation.

// File: rtl/tone_rx_pkg.sv
package tone_rx_pkg;
  localparam int ADDR_W    = 2;
  localparam int FN_W      = 3;
  localparam int VAL_W     = 6;
  localparam int CMD_W     = FN_W + VAL_W;
  localparam int FRAME_MIN = ADDR_W + CMD_W;
  localparam int CNT_W     = $clog2(FRAME_MIN + 1);

  typedef enum logic [FN_W-1:0] {
    FN_SRC  = 3'd0,
    FN_BASS = 3'd1,
    FN_TREB = 3'd2,
    FN_VOL  = 3'd3,
    FN_RF   = 3'd4,
    FN_LF   = 3'd5,
    FN_RR   = 3'd6,
    FN_LR   = 3'd7
  } fn_e;

  typedef struct packed {
    fn_e              fn;
    logic [VAL_W-1:0] val;
  } cmd_t;
endpackage

// File: rtl/tone_rx_sync.sv
module tone_rx_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] ff_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) ff_q[i] <= RST_VAL;
    end else begin
      ff_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) ff_q[i] <= ff_q[i-1];
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/tone_rx_frame.sv
module tone_rx_frame
  import tone_rx_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR = 2'b10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dat_i,
  input  logic sclk_i,
  input  logic en_ni,
  output logic cmd_vld_o,
  output cmd_t cmd_o
);
  logic             en_q, sclk_q;
  logic             en_fall, en_rise, sclk_rise;
  logic [CNT_W-1:0] cnt_q;
  logic             a_msb_q, addr_ok_q, err_q;
  logic [CMD_W-1:0] sh_q;

  assign en_fall   = en_q & ~en_ni;
  assign en_rise   = ~en_q & en_ni;
  assign sclk_rise = ~sclk_q & sclk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b1;
      sclk_q    <= 1'b0;
      cnt_q     <= '0;
      a_msb_q   <= 1'b0;
      addr_ok_q <= 1'b0;
      err_q     <= 1'b0;
      sh_q      <= '0;
      cmd_vld_o <= 1'b0;
      cmd_o     <= '0;
    end else begin
      en_q      <= en_ni;
      sclk_q    <= sclk_i;
      cmd_vld_o <= 1'b0;
      if (en_fall) begin
        cnt_q     <= '0;
        addr_ok_q <= 1'b0;
        a_msb_q   <= 1'b0;
        err_q     <= sclk_i;  // fall with clock high spoils frame
      end else if (!en_ni && sclk_rise) begin
        sh_q <= {sh_q[CMD_W-2:0], dat_i};
        if (cnt_q != CNT_W'(FRAME_MIN)) cnt_q <= cnt_q + 1'b1;
        if (cnt_q == '0) a_msb_q <= dat_i;
        if (cnt_q == CNT_W'(1)) addr_ok_q <= ({a_msb_q, dat_i} == DEV_ADDR);
      end
      if (en_rise) begin
        cmd_vld_o <= addr_ok_q && !err_q && (cnt_q == CNT_W'(FRAME_MIN));
        cmd_o     <= sh_q;
      end
    end
  end
endmodule

// File: rtl/tone_rx_bank.sv
module tone_rx_bank
  import tone_rx_pkg::*;
#(
  parameter bit CLAMP_EN  = 1'b1,
  parameter int VOL_W     = 6,
  parameter int FADE_W    = 5,
  parameter int TONE_W    = 4,
  parameter int SRC_W     = 3,
  parameter int VOL_MAX   = 40,
  parameter int FADE_MAX  = 20,
  parameter int TONE_MAX  = 12,
  parameter int TONE_FLAT = 6,
  parameter int SRC_MAX   = 4,
  parameter int NUM_FADE  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_vld_i,
  input  cmd_t              cmd_i,
  output logic [SRC_W-1:0]  src_q_o,
  output logic [TONE_W-1:0] bass_q_o,
  output logic [TONE_W-1:0] treb_q_o,
  output logic [VOL_W-1:0]  vol_q_o,
  output logic [FADE_W-1:0] fade_q_o [NUM_FADE],
  output logic              upd_o,
  output logic [FN_W-1:0]   upd_idx_o
);
  logic [VOL_W-1:0]  vol_n;
  logic [FADE_W-1:0] fade_n;
  logic [TONE_W-1:0] tone_n;
  logic [SRC_W-1:0]  src_n;

  if (CLAMP_EN) begin : g_clamp
    assign vol_n  = (cmd_i.val[VOL_W-1:0] > VOL_W'(VOL_MAX)) ? VOL_W'(VOL_MAX)
                                                              : cmd_i.val[VOL_W-1:0];
    assign fade_n = (cmd_i.val[FADE_W-1:0] > FADE_W'(FADE_MAX)) ? FADE_W'(FADE_MAX)
                                                                 : cmd_i.val[FADE_W-1:0];
    assign tone_n = (cmd_i.val[TONE_W-1:0] > TONE_W'(TONE_MAX)) ? TONE_W'(TONE_MAX)
                                                                 : cmd_i.val[TONE_W-1:0];
    assign src_n  = (cmd_i.val[SRC_W-1:0] > SRC_W'(SRC_MAX)) ? '0
                                                              : cmd_i.val[SRC_W-1:0];
  end else begin : g_raw
    assign vol_n  = cmd_i.val[VOL_W-1:0];
    assign fade_n = cmd_i.val[FADE_W-1:0];
    assign tone_n = cmd_i.val[TONE_W-1:0];
    assign src_n  = cmd_i.val[SRC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q_o   <= '0;
      bass_q_o  <= TONE_W'(TONE_FLAT);
      treb_q_o  <= TONE_W'(TONE_FLAT);
      vol_q_o   <= '0;
      upd_o     <= 1'b0;
      upd_idx_o <= '0;
    end else begin
      upd_o <= cmd_vld_i;
      if (cmd_vld_i) begin
        upd_idx_o <= cmd_i.fn;
        case (cmd_i.fn)
          FN_SRC:  src_q_o  <= src_n;
          FN_BASS: bass_q_o <= tone_n;
          FN_TREB: treb_q_o <= tone_n;
          FN_VOL:  vol_q_o  <= vol_n;
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NUM_FADE; g++) begin : g_fade
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) fade_q_o[g] <= '0;
      else if (cmd_vld_i && (cmd_i.fn == fn_e'(FN_W'(int'(FN_RF) + g))))
        fade_q_o[g] <= fade_n;
    end
  end
endmodule

// File: rtl/tone_cmd_rx.sv
module tone_cmd_rx
  import tone_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit CLAMP_EN    = 1'b1,
  parameter int VOL_MAX     = 40,
  parameter int FADE_MAX    = 20,
  parameter int TONE_MAX    = 12,
  parameter int TONE_FLAT   = 6,
  parameter int SRC_MAX     = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ser_data_i,
  input  logic       ser_clk_i,
  input  logic       ser_en_ni,
  output logic [2:0] src_sel_o,
  output logic [3:0] bass_o,
  output logic [3:0] treble_o,
  output logic [5:0] volume_o,
  output logic [4:0] fade_rf_o,
  output logic [4:0] fade_lf_o,
  output logic [4:0] fade_rr_o,
  output logic [4:0] fade_lr_o,
  output logic       upd_o,
  output logic [2:0] upd_idx_o
);
  localparam int NUM_FADE = 4;

  logic [2:0] pins_s;
  logic       cmd_vld;
  cmd_t       cmd;
  logic [4:0] fade_q [NUM_FADE];

  tone_rx_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ser_en_ni, ser_clk_i, ser_data_i}),
    .q_o    (pins_s)
  );

  tone_rx_frame u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dat_i     (pins_s[0]),
    .sclk_i    (pins_s[1]),
    .en_ni     (pins_s[2]),
    .cmd_vld_o (cmd_vld),
    .cmd_o     (cmd)
  );

  tone_rx_bank #(
    .CLAMP_EN (CLAMP_EN), .VOL_W(6), .FADE_W(5), .TONE_W(4), .SRC_W(3),
    .VOL_MAX  (VOL_MAX), .FADE_MAX(FADE_MAX), .TONE_MAX(TONE_MAX),
    .TONE_FLAT(TONE_FLAT), .SRC_MAX(SRC_MAX), .NUM_FADE(NUM_FADE)
  ) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_vld_i (cmd_vld),
    .cmd_i     (cmd),
    .src_q_o   (src_sel_o),
    .bass_q_o  (bass_o),
    .treb_q_o  (treble_o),
    .vol_q_o   (volume_o),
    .fade_q_o  (fade_q),
    .upd_o     (upd_o),
    .upd_idx_o (upd_idx_o)
  );

  assign fade_rf_o = fade_q[0];
  assign fade_lf_o = fade_q[1];
  assign fade_rr_o = fade_q[2];
  assign fade_lr_o = fade_q[3];
endmodule

// File: rtl/tone_cmd_rx_chk.sv
module tone_cmd_rx_chk #(
  parameter bit CLAMP_EN = 1'b1,
  parameter int VOL_MAX  = 40,
  parameter int FADE_MAX = 20,
  parameter int TONE_MAX = 12,
  parameter int SRC_MAX  = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ser_en_ni,
  input logic [2:0] src_sel_o,
  input logic [3:0] bass_o,
  input logic [3:0] treble_o,
  input logic [5:0] volume_o,
  input logic [4:0] fade_rf_o,
  input logic [4:0] fade_lf_o,
  input logic [4:0] fade_rr_o,
  input logic [4:0] fade_lr_o,
  input logic       upd_o
);
  AST_UPD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> !upd_o);  // R4

  AST_NO_UPD_EN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_en_ni |-> !upd_o);  // R4

  AST_HOLD_VOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_o |-> $stable(volume_o));  // R11

  AST_HOLD_TONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_o |-> ($stable(bass_o) && $stable(treble_o)));  // R11

  AST_HOLD_FADE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_o |-> ($stable(fade_rf_o) && $stable(fade_lf_o)
                && $stable(fade_rr_o) && $stable(fade_lr_o) && $stable(src_sel_o)));  // R11

  if (CLAMP_EN) begin : g_rng
    AST_VOL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      volume_o <= 6'(VOL_MAX));  // R7
    AST_FADE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fade_rf_o <= 5'(FADE_MAX) && fade_lf_o <= 5'(FADE_MAX)
      && fade_rr_o <= 5'(FADE_MAX) && fade_lr_o <= 5'(FADE_MAX));  // R8
    AST_TONE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bass_o <= 4'(TONE_MAX) && treble_o <= 4'(TONE_MAX));  // R9
    AST_SRC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      src_sel_o <= 3'(SRC_MAX));  // R10
  end
endmodule

bind tone_cmd_rx tone_cmd_rx_chk #(
  .CLAMP_EN(CLAMP_EN), .VOL_MAX(VOL_MAX), .FADE_MAX(FADE_MAX),
  .TONE_MAX(TONE_MAX), .SRC_MAX(SRC_MAX)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ser_en_ni (ser_en_ni),
  .src_sel_o (src_sel_o),
  .bass_o    (bass_o),
  .treble_o  (treble_o),
  .volume_o  (volume_o),
  .fade_rf_o (fade_rf_o),
  .fade_lf_o (fade_lf_o),
  .fade_rr_o (fade_rr_o),
  .fade_lr_o (fade_lr_o),
  .upd_o     (upd_o)
);

// File: tb/tone_cmd_rx_tb.sv
module tone_cmd_rx_tb;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_data = 1'b0, ser_clk = 1'b0, ser_en_n = 1'b1;
  logic [2:0] src_sel, upd_idx;
  logic [3:0] bass, treble;
  logic [5:0] volume;
  logic [4:0] f_rf, f_lf, f_rr, f_lr;
  logic       upd;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  int exp_reg [8];
  int q_fn [$];
  int q_val [$];

  always #2 clk = ~clk;

  tone_cmd_rx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ser_data_i(ser_data), .ser_clk_i(ser_clk),
    .ser_en_ni(ser_en_n), .src_sel_o(src_sel), .bass_o(bass), .treble_o(treble),
    .volume_o(volume), .fade_rf_o(f_rf), .fade_lf_o(f_lf), .fade_rr_o(f_rr),
    .fade_lr_o(f_lr), .upd_o(upd), .upd_idx_o(upd_idx)
  );

  function automatic int get_out(int fn);
    case (fn)
      0: return int'(src_sel);
      1: return int'(bass);
      2: return int'(treble);
      3: return int'(volume);
      4: return int'(f_rf);
      5: return int'(f_lf);
      6: return int'(f_rr);
      default: return int'(f_lr);
    endcase
  endfunction

  function automatic int legal(int fn, int v);
    int r;
    case (fn)
      0: begin r = v % 8;  if (r > 4) r = 0; end
      1, 2: begin r = v % 16; if (r > 12) r = 12; end
      3: begin r = v; if (r > 40) r = 40; end
      default: begin r = v % 32; if (r > 20) r = 20; end
    endcase
    return r;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(string req);
    for (int i = 0; i < 8; i++) check(req, get_out(i), exp_reg[i]);
    check({req, " pending"}, q_fn.size(), 0);
  endtask

  // driver: sends a frame MSB first and predicts its effect
  task automatic send_frame(logic [31:0] bits, int n, bit clk_hi_fall);
    int fn, v;
    if (n >= 11 && bits[n-1] && !bits[n-2] && !clk_hi_fall) begin
      fn = int'(bits[8:6]);
      v  = int'(bits[5:0]);
      q_fn.push_back(fn);
      q_val.push_back(legal(fn, v));
      exp_reg[fn] = legal(fn, v);
    end
    if (clk_hi_fall) begin ser_clk = 1'b1; wait_cyc(HALF); end
    ser_en_n = 1'b0; wait_cyc(HALF);
    ser_clk = 1'b0;  wait_cyc(HALF);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = bits[i]; wait_cyc(HALF);
      ser_clk = 1'b1;     wait_cyc(HALF);
      ser_clk = 1'b0;
    end
    wait_cyc(HALF);
    ser_en_n = 1'b1;
    wait_cyc(20);
    ser_data = 1'b0;
  endtask

  function automatic logic [31:0] mk(int fn, int v);
    return {21'd0, 2'b10, 3'(fn), 6'(v)};
  endfunction

  // monitor: pops expected writes as strobes appear
  always @(negedge clk) begin
    if (rst_n && upd) begin
      if (q_fn.size() == 0) begin
        check("R4 unexpected strobe", int'(upd_idx), -1);
      end else begin
        int fn, v;
        fn = q_fn.pop_front();
        v  = q_val.pop_front();
        check("R4 strobe index", int'(upd_idx), fn);
        check("R7-10 stored value", get_out(fn), v);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    exp_reg = '{0, 6, 6, 0, 0, 0, 0, 0};
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);
    check_all("R6 reset");

    send_frame(mk(3, 40), 11, 1'b0);    check_all("R7 volume max");
    send_frame(mk(3, 63), 11, 1'b0);    check_all("R7 volume clamp");
    send_frame(mk(3, 17), 11, 1'b0);    check_all("R11 volume mid");
    send_frame(mk(2, 12), 11, 1'b0);    check_all("R9 treble top");
    send_frame(mk(1, 15), 11, 1'b0);    check_all("R9 bass clamp");
    send_frame(mk(1, 6'b110011), 11, 1'b0); check_all("R9 bass upper bits");
    send_frame(mk(4, 10), 11, 1'b0);    check_all("R8 fader rf");
    send_frame(mk(5, 6'b100101), 11, 1'b0); check_all("R8 fader lf top bit");
    send_frame(mk(6, 27), 11, 1'b0);    check_all("R8 fader rr clamp");
    send_frame(mk(7, 20), 11, 1'b0);    check_all("R8 fader lr");
    send_frame(mk(0, 3), 11, 1'b0);     check_all("R10 source 3");
    send_frame(mk(0, 6), 11, 1'b0);     check_all("R10 source open");

    // R2: wrong addresses
    send_frame({21'd0, 2'b11, 3'd3, 6'd5}, 11, 1'b0); check_all("R2 addr 11");
    send_frame({21'd0, 2'b00, 3'd3, 6'd5}, 11, 1'b0); check_all("R2 addr 00");
    // R3: padded frame, last nine bits used
    send_frame({16'd0, 2'b10, 5'b11011, 3'd4, 6'd7}, 16, 1'b0); check_all("R3 padded");
    // R3: too short
    send_frame({22'd0, 2'b10, 2'd3, 6'd9}, 10, 1'b0); check_all("R3 short");
    // R5: enable falls with clock high
    send_frame(mk(3, 2), 11, 1'b1);     check_all("R5 clock high at fall");
    // R1: clock activity with enable high
    begin
      logic [10:0] pat;
      pat = {2'b10, 3'd3, 6'd1};
      for (int i = 10; i >= 0; i--) begin
        ser_data = pat[i]; wait_cyc(HALF);
        ser_clk = 1'b1;    wait_cyc(HALF);
        ser_clk = 1'b0;
      end
      wait_cyc(20);
    end
    check_all("R1 enable high");
    // R1: stray bits ignored, next frame still valid
    send_frame(mk(3, 8), 11, 1'b0);     check_all("R1 after idle");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule